// File: doc/BRIEF.md
# Illegal Instruction Exception Sequencer

This block watches the decode stage of a small CPU pipeline for two kinds of illegal instruction. It also runs the exception entry that follows. The first kind is a slot fault: an undefined opcode, or any instruction that writes the program counter, decoded in the slot right after a delayed branch. The second kind is a general fault: an undefined opcode decoded anywhere else. Valid opcodes outside a slot, including ones that write the PC, pass through untouched.

When a fault is accepted, the block takes a snapshot of the status word, the stack pointer, the vector base and a return address. It then runs a fixed memory sequence through a single request/acknowledge port. It pushes the status word, then pushes the return address, then reads one handler address from the vector table. Finally it loads the new PC and the new stack pointer in a single cycle. The return address depends on the fault kind. A slot fault returns to the pending branch target. A general fault returns to the address of the offending opcode.

While the sequence runs, the `busy` output stalls the decoder. Decode flags presented during that time are ignored.

Top module: `illegal_exc_seq`

## Requirements
- R1: With `dec_valid`=1 and `dec_in_slot`=1, `dec_undef`=1 raises a slot fault. A slot fault uses vector number SLOT_VEC (default 6).
- R2: With `dec_valid`=1 and `dec_in_slot`=1, `dec_pc_write`=1 raises a slot fault even when `dec_undef`=0.
- R3: With `dec_in_slot`=0, only `dec_undef`=1 raises a fault, and it is a general fault with vector number GEN_VEC (default 4). A PC-writing opcode or a plain opcode raises nothing: no memory request and no `busy`. The same holds for a slot instruction that is neither undefined nor PC-writing.
- R4: The first memory access of a sequence is a write (`mem_we`=1) of the captured SR to address SP−4.
- R5: The second access is a write of the return address to SP−8. For a slot fault the return address is the captured branch target.
- R6: For a general fault the return address written is the captured `cur_pc`, the opcode's own address.
- R7: The third access is a read (`mem_we`=0) at vector_base + 4 × vector_number. It is issued only after the second write has been acknowledged.
- R8: After the read is acknowledged, `pc_load` and `sp_load` are high for exactly one cycle. `pc_out` equals the data that was read, and `sp_out` equals the captured SP−8.
- R9: `busy` rises on the clock edge that accepts the fault and stays high through the `pc_load` cycle, so there are 3×(wait+1)+1 busy cycles. Decode flags presented while `busy` is high start nothing.
- R10: A memory request holds its address, data and direction stable until `mem_ack` is seen on a clock edge. Each access may take any number of wait cycles.
- R11: An asynchronous reset (`rst_n`=0) returns the block to idle: `busy`, `mem_req`, `pc_load` and `sp_load` all go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is being decoded this cycle |
| dec_in_slot | input | 1 | The instruction sits in a delayed-branch slot |
| dec_undef | input | 1 | The opcode is undefined |
| dec_pc_write | input | 1 | The opcode writes the program counter |
| cur_pc | input | 32 | Address of the decoded instruction |
| br_target | input | 32 | Target of the pending delayed branch |
| sr_in | input | 32 | Current status register |
| sp_in | input | 32 | Current stack pointer |
| vbase_in | input | 32 | Vector table base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes on this edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Sequence in progress; decode must stall |
| pc_load | output | 1 | Load `pc_out` into the PC |
| pc_out | output | 32 | Handler address |
| sp_load | output | 1 | Load `sp_out` into the stack pointer |
| sp_out | output | 32 | Stack pointer after both pushes |

## Verification
The bench runs the four flag combinations that matter inside a slot: undefined, PC-writing, both, and neither. It also runs undefined and PC-writing opcodes outside a slot. Together these separate the two fault classes from the no-fault cases and show which return address and vector each class selects. Every case uses different SR, SP, PC, target and base values, so a swapped field or offset cannot go unnoticed. Further runs add memory wait states, hold conflicting decode flags high for a whole sequence, and reset the block partway through.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_SR = 3'd1,
    ST_PUSH_PC = 3'd2,
    ST_VEC_RD  = 3'd3,
    ST_LOAD    = 3'd4
  } exc_state_e;
endpackage

// File: rtl/exc_classify.sv
module exc_classify #(
  parameter int VEC_W    = 8,
  parameter int SLOT_VEC = 6,
  parameter int GEN_VEC  = 4
) (
  input  logic             accept,
  input  logic             dec_valid,
  input  logic             dec_in_slot,
  input  logic             dec_undef,
  input  logic             dec_pc_write,
  output logic             fault,
  output logic             is_slot,
  output logic [VEC_W-1:0] vec_num
);
  localparam logic [VEC_W-1:0] SLOT_NUM = VEC_W'(SLOT_VEC);
  localparam logic [VEC_W-1:0] GEN_NUM  = VEC_W'(GEN_VEC);

  logic slot_hit;
  logic gen_hit;

  always_comb begin
    slot_hit = dec_in_slot & (dec_undef | dec_pc_write);
    gen_hit  = ~dec_in_slot & dec_undef;
    fault    = accept & dec_valid & (slot_hit | gen_hit);
    is_slot  = slot_hit;
    vec_num  = slot_hit ? SLOT_NUM : GEN_NUM;
  end
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen
  import exc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int VEC_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             handler_we,
  input  exc_state_e       state,
  input  logic             is_slot,
  input  logic [VEC_W-1:0] vec_num,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  br_target,
  input  logic [XLEN-1:0]  sr_in,
  input  logic [XLEN-1:0]  sp_in,
  input  logic [XLEN-1:0]  vbase_in,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic [XLEN-1:0]  sp_new,
  output logic [XLEN-1:0]  pc_new
);
  localparam int              SHIFT = $clog2(WORD_BYTES);
  localparam logic [XLEN-1:0] STEP1 = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * WORD_BYTES);

  logic [XLEN-1:0] sr_q, ret_q, sp_q, vaddr_q, handler_q;
  logic [XLEN-1:0] ret_d, vaddr_d;

  always_comb begin
    ret_d   = is_slot ? br_target : cur_pc;
    vaddr_d = vbase_in + (XLEN'(vec_num) << SHIFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      ret_q   <= '0;
      sp_q    <= '0;
      vaddr_q <= '0;
    end else if (capture) begin
      sr_q    <= sr_in;
      ret_q   <= ret_d;
      sp_q    <= sp_in;
      vaddr_q <= vaddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          handler_q <= '0;
    else if (handler_we) handler_q <= mem_rdata;
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_PUSH_SR: begin mem_addr = sp_q - STEP1; mem_wdata = sr_q;  end
      ST_PUSH_PC: begin mem_addr = sp_q - STEP2; mem_wdata = ret_q; end
      ST_VEC_RD:  mem_addr = vaddr_q;
      default: ;
    endcase
    sp_new = sp_q - STEP2;
    pc_new = handler_q;
  end
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault,
  input  logic       mem_ack,
  output exc_state_e state,
  output logic       accept,
  output logic       capture,
  output logic       handler_we,
  output logic       mem_req,
  output logic       mem_we,
  output logic       busy,
  output logic       pc_load,
  output logic       sp_load
);
  exc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (fault)   state_d = ST_PUSH_SR;
      ST_PUSH_SR: if (mem_ack) state_d = ST_PUSH_PC;
      ST_PUSH_PC: if (mem_ack) state_d = ST_VEC_RD;
      ST_VEC_RD:  if (mem_ack) state_d = ST_LOAD;
      ST_LOAD:                 state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state      = state_q;
    accept     = (state_q == ST_IDLE);
    capture    = fault;
    mem_req    = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC) || (state_q == ST_VEC_RD);
    mem_we     = (state_q == ST_PUSH_SR) || (state_q == ST_PUSH_PC);
    handler_we = (state_q == ST_VEC_RD) && mem_ack;
    busy       = (state_q != ST_IDLE);
    pc_load    = (state_q == ST_LOAD);
    sp_load    = (state_q == ST_LOAD);
  end

  // R8: the load strobe never lasts two cycles
  assert_single_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
  // R9: busy drops only after the load cycle
  assert_busy_until_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pc_load));
endmodule

// File: rtl/illegal_exc_seq.sv
module illegal_exc_seq
  import exc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int VEC_W      = 8,
  parameter int SLOT_VEC   = 6,
  parameter int GEN_VEC    = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_valid,
  input  logic            dec_in_slot,
  input  logic            dec_undef,
  input  logic            dec_pc_write,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] sr_in,
  input  logic [XLEN-1:0] sp_in,
  input  logic [XLEN-1:0] vbase_in,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            busy,
  output logic            pc_load,
  output logic [XLEN-1:0] pc_out,
  output logic            sp_load,
  output logic [XLEN-1:0] sp_out
);
  exc_state_e       state;
  logic             accept, capture, handler_we, fault, is_slot;
  logic [VEC_W-1:0] vec_num;

  exc_classify #(.VEC_W(VEC_W), .SLOT_VEC(SLOT_VEC), .GEN_VEC(GEN_VEC)) u_cls (
    .accept(accept), .dec_valid(dec_valid), .dec_in_slot(dec_in_slot),
    .dec_undef(dec_undef), .dec_pc_write(dec_pc_write),
    .fault(fault), .is_slot(is_slot), .vec_num(vec_num)
  );

  exc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fault(fault), .mem_ack(mem_ack),
    .state(state), .accept(accept), .capture(capture), .handler_we(handler_we),
    .mem_req(mem_req), .mem_we(mem_we), .busy(busy),
    .pc_load(pc_load), .sp_load(sp_load)
  );

  exc_addr_gen #(.XLEN(XLEN), .VEC_W(VEC_W), .WORD_BYTES(WORD_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .capture(capture), .handler_we(handler_we),
    .state(state), .is_slot(is_slot), .vec_num(vec_num),
    .cur_pc(cur_pc), .br_target(br_target), .sr_in(sr_in), .sp_in(sp_in),
    .vbase_in(vbase_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_new(sp_out), .pc_new(pc_out)
  );

  // R4: the first access after acceptance writes the SR snapshot below SP
  assert_sr_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_req && mem_we && mem_addr == $past(sp_in) - XLEN'(WORD_BYTES)
                     && mem_wdata == $past(sr_in)));
  // R7: the vector read only begins right after an acknowledged write
  assert_vec_after_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && !mem_we) |-> $past(mem_req && mem_we && mem_ack));
  // R10: an unacknowledged request is held unchanged
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  // R11: no request while idle
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !pc_load));
endmodule

// File: tb/sim_illegal_exc_seq.sv
module sim_illegal_exc_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_valid, dec_in_slot, dec_undef, dec_pc_write;
  logic [31:0] cur_pc, br_target, sr_in, sp_in, vbase_in;
  logic        mem_req, mem_we, mem_ack, busy, pc_load, sp_load;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_out, sp_out;

  int total = 0, bad = 0;
  int lat = 0, wcnt = 0;
  int nlog = 0, busy_cnt = 0, hold_err = 0, nload = 0;
  logic [31:0] log_addr [8];
  logic [31:0] log_data [8];
  logic        log_we   [8];
  logic [31:0] ld_pc, ld_sp;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;

  always #2 clk = ~clk;

  illegal_exc_seq u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_in_slot(dec_in_slot),
    .dec_undef(dec_undef), .dec_pc_write(dec_pc_write), .cur_pc(cur_pc),
    .br_target(br_target), .sr_in(sr_in), .sp_in(sp_in), .vbase_in(vbase_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .pc_load(pc_load),
    .pc_out(pc_out), .sp_load(sp_load), .sp_out(sp_out)
  );

  assign mem_rdata = mem_addr ^ 32'hA5A5_0000;

  // memory responder and monitor, all at the falling edge
  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (pc_load) begin nload++; ld_pc = pc_out; ld_sp = sp_out; end
    if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_err++;
    if (mem_req) begin
      if (wcnt == lat) begin
        mem_ack = 1'b1; wcnt = 0;
        if (nlog < 8) begin
          log_addr[nlog] = mem_addr; log_data[nlog] = mem_wdata; log_we[nlog] = mem_we;
        end
        nlog++;
        prev_wait = 1'b0;
      end else begin
        mem_ack = 1'b0; wcnt++; prev_wait = 1'b1; prev_addr = mem_addr;
      end
    end else begin
      mem_ack = 1'b0; wcnt = 0; prev_wait = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic        V_SLOT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic        V_UND  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic        V_PCW  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] V_PC   [NV] = '{32'h1000, 32'h1104, 32'h2208, 32'h330C, 32'h4410, 32'h5514};
  localparam logic [31:0] V_TGT  [NV] = '{32'h8000, 32'h8140, 32'h8280, 32'h83C0, 32'h8400, 32'h8540};
  localparam logic [31:0] V_SR   [NV] = '{32'h0F0, 32'h1E1, 32'h2D2, 32'h3C3, 32'h4B4, 32'h5A5};
  localparam logic [31:0] V_SP   [NV] = '{32'hF000, 32'hE100, 32'hD200, 32'hC300, 32'hB400, 32'hA500};
  localparam logic [31:0] V_VB   [NV] = '{32'h0, 32'h400, 32'h800, 32'hC00, 32'h1000, 32'h1400};
  localparam int          V_LAT  [NV] = '{0, 1, 0, 0, 0, 3};

  task automatic clear_log();
    nlog = 0; busy_cnt = 0; nload = 0; hold_err = 0;
  endtask

  // present one instruction; hold = keep decode flags asserted for the whole run
  task automatic run_case(input bit s, input bit u, input bit w, input logic [31:0] pc,
                          input logic [31:0] tg, input logic [31:0] sr, input logic [31:0] sp,
                          input logic [31:0] vb, input int l, input bit hold, input string tag);
    bit fault, slot;
    logic [31:0] vec, ret;
    int guard;
    fault = (s && (u || w)) || (!s && u);
    slot  = s;
    vec   = slot ? 32'd6 : 32'd4;
    ret   = slot ? tg : pc;
    @(negedge clk);
    clear_log(); lat = l;
    dec_valid = 1'b1; dec_in_slot = s; dec_undef = u; dec_pc_write = w;
    cur_pc = pc; br_target = tg; sr_in = sr; sp_in = sp; vbase_in = vb;
    @(negedge clk);
    if (hold) begin
      dec_in_slot = ~s; dec_undef = 1'b1; dec_pc_write = 1'b1;
      cur_pc = 32'hDEAD_0000; br_target = 32'hBEEF_0000; sr_in = 32'h7777;
      sp_in = 32'h0100; vbase_in = 32'h0F00;
    end else dec_valid = 1'b0;
    if (fault) begin
      guard = 0;
      while (!pc_load && guard < 200) begin @(negedge clk); guard++; end
      dec_valid = 1'b0;
      check(guard < 200, {tag, " R8 timeout"}, 32'(guard), 32'd200);
      @(negedge clk);
      check(nlog == 3, {tag, " R7 access count"}, 32'(nlog), 32'd3);
      check(log_we[0] && log_addr[0] == sp - 4 && log_data[0] == sr, {tag, " R4 SR push"}, log_addr[0], sp - 4);
      check(log_we[1] && log_addr[1] == sp - 8 && log_data[1] == ret,
            {tag, slot ? " R5 slot return" : " R6 general return"}, log_data[1], ret);
      check(!log_we[2] && log_addr[2] == vb + 4 * vec,
            {tag, slot ? " R1 R2 slot vector" : " R3 general vector"}, log_addr[2], vb + 4 * vec);
      check(nload == 1 && ld_pc == ((vb + 4 * vec) ^ 32'hA5A5_0000) && ld_sp == sp - 8,
            {tag, " R8 load"}, ld_pc, (vb + 4 * vec) ^ 32'hA5A5_0000);
      check(busy_cnt == 3 * (l + 1) + 1 && !busy, {tag, " R9 busy span"}, 32'(busy_cnt), 32'(3 * (l + 1) + 1));
      check(hold_err == 0, {tag, " R10 request hold"}, 32'(hold_err), 32'd0);
    end else begin
      repeat (8) @(negedge clk);
      check(nlog == 0 && busy_cnt == 0 && nload == 0, {tag, " R3 no fault"}, 32'(nlog + busy_cnt), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mem_ack = 1'b0;
    dec_valid = 1'b0; dec_in_slot = 1'b0; dec_undef = 1'b0; dec_pc_write = 1'b0;
    cur_pc = '0; br_target = '0; sr_in = '0; sp_in = '0; vbase_in = '0;
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !pc_load && !sp_load, "R11 reset state", {28'd0, busy, mem_req, pc_load, sp_load}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_case(V_SLOT[i], V_UND[i], V_PCW[i], V_PC[i], V_TGT[i], V_SR[i], V_SP[i], V_VB[i],
               V_LAT[i], 1'b0, $sformatf("vec%0d", i));

    // slot with both flags set, with wait states
    run_case(1'b1, 1'b1, 1'b1, 32'h6000, 32'h9000, 32'h66, 32'h7000, 32'h200, 2, 1'b0, "both");
    // R9: conflicting decode flags held high during the whole sequence are ignored
    run_case(1'b0, 1'b1, 1'b0, 32'h7700, 32'h9900, 32'h77, 32'h6000, 32'h300, 1, 1'b1, "hold");

    // R11: reset partway through a sequence
    @(negedge clk);
    clear_log(); lat = 5;
    dec_valid = 1'b1; dec_in_slot = 1'b0; dec_undef = 1'b1; dec_pc_write = 1'b0;
    @(negedge clk); dec_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!busy && !mem_req && !pc_load, "R11 mid-sequence reset", {29'd0, busy, mem_req, pc_load}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    lat = 0;
    run_case(1'b1, 1'b0, 1'b1, 32'hAB00, 32'hCD00, 32'h11, 32'h5000, 32'h40, 0, 1'b0, "after_rst");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule